// File: doc/BRIEF.md
# Multi-Channel Command Semaphore Controller

This block is the register-level control for a command processor with four independent channels. Every channel owns a command-pointer register, a semaphore counter and a status register. A global status register holds one completion bit per channel, and a channel-enable register gates all of them. Software loads a channel's pointer and then adds to its semaphore to launch work. While the semaphore is nonzero and the channel is enabled, the channel keeps issuing the command held in its pointer.

A stub work engine inside each channel stands in for descriptor fetch and the datapaths. It finishes every command after a fixed latency. Three low bits of the pointer act as command control bits. They decide whether the semaphore is decremented on completion, whether an interrupt is raised, and whether the stub reports an error.

A small allocator hands out channels to software clients. It grants the lowest-numbered free channel, reports busy when every channel is held, and takes back channels on release.

Top module: `cmdsem_ctrl`

## Requirements
- R1: After reset every register reads zero and no channel is held. Register addresses are 5 bits wide. Address 0 reads the global status, address 1 reads zero and address 2 reads the enable mask. Channel c uses address {1'b1, c[1:0], sel}: sel 0 is the pointer, sel 1 the semaphore, sel 2 the status, and sel 3 reads zero. The read port is combinational.
- R2: A channel that is idle, enabled and has a nonzero semaphore starts on the next clock edge and latches its pointer's control bits at that edge. A channel whose semaphore is zero or that is disabled stays idle. A started command completes LAT clock edges after its start edge (LAT=4 by default). Status bit 0 reads 1 while the command runs.
- R3: Completion on channel c sets bit c of the global status. A completion in the same cycle as a clear of that bit leaves the bit set.
- R4: Any write to a channel's status register clears both its error field (status bits [15:8]) and its interrupt-pending bit (status bit 1). A completion in the same cycle takes effect after the clear.
- R5: A semaphore write adds wdata[7:0] to the count, saturating at 255. A completion whose latched pointer bit 0 is set then subtracts one from the result of that addition, in the same cycle.
- R6: A completion whose latched pointer bit 2 is clear and bit 1 is set raises the channel's interrupt-pending bit. Output irq is the OR of all pending bits.
- R7: A completion whose latched pointer bit 2 is set ORs error code 1 into the channel's error field. A nonzero error field marks the command as failed. A completion with bit 2 clear leaves the field unchanged.
- R8: On alloc_req the allocator grants the lowest channel that is not held and marks it held. If every channel is held, it asserts alloc_busy and grants nothing. A release frees a channel from the next cycle on, so a release and a request in the same cycle do not see each other.
- R9: Address 2 holds the enable mask in bits [3:0]. Clearing a bit stops further starts on that channel, but a command already running still completes. Writing address 1 clears the global status bits at the 1 positions of wdata. A write to address 0 has no effect.
- R10: A command whose latched pointer bit 0 is clear leaves the semaphore unchanged. The channel therefore repeats the command for as long as it stays enabled with a nonzero count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 5 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| alloc_req | input | 1 | Request a free channel |
| alloc_gnt | output | 1 | A channel was granted this cycle |
| alloc_id | output | 2 | Granted channel number |
| alloc_busy | output | 1 | Request refused: all channels held |
| rel_en | input | 1 | Release a held channel |
| rel_id | input | 2 | Channel to release |
| irq | output | 1 | OR of the per-channel interrupt-pending bits |

## Verification
Two pairs of functions can land on the same clock edge. A semaphore increment can arrive on the edge where a completion decrements the count, and a global-status clear, or a channel-status clear, can arrive on the edge where a completion sets the same bits. The bench provokes both by writing the semaphore, the clear alias or the status register on every cycle while a short-latency channel repeatedly completes, so that the two events are bound to coincide on some edges. A behavioural model advances its counts in the order given by R3, R4 and R5, and every register read and output is compared with the model on every clock. An allocator request that arrives together with a release is also compared, to confirm that the freed channel is not granted in that same cycle.

// File: rtl/cmdsem_pkg.sv
package cmdsem_pkg;
   typedef enum logic [1:0] {
      SEL_PTR  = 2'd0,
      SEL_SEMA = 2'd1,
      SEL_STAT = 2'd2,
      SEL_NONE = 2'd3
   } chan_sel_e;

   localparam logic [1:0] GADDR_STAT = 2'd0;
   localparam logic [1:0] GADDR_CLR  = 2'd1;
   localparam logic [1:0] GADDR_EN   = 2'd2;

   localparam int CTL_DEC     = 0;
   localparam int CTL_IRQ     = 1;
   localparam int CTL_ERR     = 2;
   localparam int CTL_W       = 3;
   localparam int STAT_ERR_LO = 8;
endpackage

// File: rtl/cmdsem_alloc.sv
module cmdsem_alloc #(
   parameter int NCH = 4,
   localparam int CW = $clog2(NCH)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           req_i,
   input  logic           rel_en_i,
   input  logic [CW-1:0]  rel_id_i,
   output logic           gnt_o,
   output logic [CW-1:0]  id_o,
   output logic           busy_o,
   output logic [NCH-1:0] lock_o
);
   logic [NCH-1:0] lock_q, rel_mask, gnt_mask;
   logic           found;

   always_comb begin
      found = 1'b0;
      id_o  = '0;
      for (int i = NCH - 1; i >= 0; i--) begin
         if (!lock_q[i]) begin
            found = 1'b1;
            id_o  = CW'(i);
         end
      end
      gnt_o    = req_i && found;
      busy_o   = req_i && !found;
      rel_mask = rel_en_i ? (NCH'(1) << rel_id_i) : '0;
      gnt_mask = gnt_o ? (NCH'(1) << id_o) : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lock_q <= '0;
      else        lock_q <= (lock_q & ~rel_mask) | gnt_mask;
   end

   assign lock_o = lock_q;
endmodule

// File: rtl/cmdsem_chan.sv
module cmdsem_chan
   import cmdsem_pkg::*;
#(
   parameter int DW   = 32,
   parameter int SEMW = 8,
   parameter int ERRW = 8,
   parameter int LAT  = 4,
   localparam int CNTW = (LAT > 1) ? $clog2(LAT) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en_i,
   input  logic            wr_ptr_i,
   input  logic            wr_sema_i,
   input  logic            wr_stat_i,
   input  logic [DW-1:0]   wdata_i,
   output logic [DW-1:0]   ptr_o,
   output logic [SEMW-1:0] sema_o,
   output logic            run_o,
   output logic            irqp_o,
   output logic [ERRW-1:0] err_o,
   output logic            done_o
);
   localparam logic [SEMW-1:0] SEMA_MAX = '1;

   logic [DW-1:0]    ptr_q;
   logic [SEMW-1:0]  sema_q, sema_sat, sema_n;
   logic [SEMW:0]    sema_sum;
   logic [CTL_W-1:0] ctl_q;
   logic             run_q, irqp_q, start, done;
   logic [ERRW-1:0]  err_q;

   assign start = !run_q && en_i && (sema_q != '0);

   generate
      if (LAT == 1) begin : g_single
         assign done = run_q;
      end else begin : g_timer
         logic [CNTW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                    cnt_q <= '0;
            else if (start)                cnt_q <= CNTW'(LAT - 1);
            else if (run_q && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
         end
         assign done = run_q && (cnt_q == '0);
      end
   endgenerate

   always_comb begin
      sema_sum = {1'b0, sema_q} + {1'b0, (wr_sema_i ? wdata_i[SEMW-1:0] : '0)};
      sema_sat = sema_sum[SEMW] ? SEMA_MAX : sema_sum[SEMW-1:0];
      if (done && ctl_q[CTL_DEC] && sema_sat != '0) sema_n = sema_sat - 1'b1;
      else                                          sema_n = sema_sat;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q  <= '0;
         sema_q <= '0;
         ctl_q  <= '0;
         run_q  <= 1'b0;
         irqp_q <= 1'b0;
         err_q  <= '0;
      end else begin
         sema_q <= sema_n;
         if (wr_ptr_i) ptr_q <= wdata_i;
         if (start) begin
            run_q <= 1'b1;
            ctl_q <= ptr_q[CTL_W-1:0];
         end else if (done) begin
            run_q <= 1'b0;
         end
         if (done && ctl_q[CTL_ERR])
            err_q <= (wr_stat_i ? '0 : err_q) | ERRW'(1);
         else if (wr_stat_i)
            err_q <= '0;
         if (done && !ctl_q[CTL_ERR] && ctl_q[CTL_IRQ]) irqp_q <= 1'b1;
         else if (wr_stat_i)                            irqp_q <= 1'b0;
      end
   end

   assign ptr_o  = ptr_q;
   assign sema_o = sema_q;
   assign run_o  = run_q;
   assign irqp_o = irqp_q;
   assign err_o  = err_q;
   assign done_o = done;
endmodule

// File: rtl/cmdsem_ctrl.sv
module cmdsem_ctrl
   import cmdsem_pkg::*;
#(
   parameter int NCH  = 4,
   parameter int DW   = 32,
   parameter int SEMW = 8,
   parameter int ERRW = 8,
   parameter int LAT  = 4,
   localparam int CW  = $clog2(NCH),
   localparam int AW  = CW + 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data,
   input  logic          alloc_req,
   output logic          alloc_gnt,
   output logic [CW-1:0] alloc_id,
   output logic          alloc_busy,
   input  logic          rel_en,
   input  logic [CW-1:0] rel_id,
   output logic          irq
);
   generate
      if (NCH < 2 || (1 << CW) != NCH) begin : g_bad_nch
         $error("NCH must be a power of two and at least 2");
      end
      if (LAT < 1) begin : g_bad_lat
         $error("LAT must be at least 1");
      end
      if (DW < STAT_ERR_LO + ERRW || DW < SEMW || DW < NCH) begin : g_bad_dw
         $error("DW too narrow for the status, semaphore or mask fields");
      end
   endgenerate

   logic [NCH-1:0]  chen_q, gstat_q, gclr_mask;
   logic [NCH-1:0]  chan_done, chan_run, sema_nz, chan_lock, irqp_v;
   logic [NCH-1:0]  wr_ptr_v, wr_sema_v, wr_stat_v;
   logic [DW-1:0]   ptr_v  [NCH];
   logic [SEMW-1:0] sema_v [NCH];
   logic [ERRW-1:0] err_v  [NCH];

   logic            wr_glob, wr_chan;
   logic [CW-1:0]   wr_ch;
   chan_sel_e       wr_sel;

   assign wr_glob = wr_en && !wr_addr[AW-1];
   assign wr_chan = wr_en &&  wr_addr[AW-1];
   assign wr_ch   = wr_addr[2 +: CW];
   assign wr_sel  = chan_sel_e'(wr_addr[1:0]);

   cmdsem_alloc #(.NCH(NCH)) u_alloc (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_i    (alloc_req),
      .rel_en_i (rel_en),
      .rel_id_i (rel_id),
      .gnt_o    (alloc_gnt),
      .id_o     (alloc_id),
      .busy_o   (alloc_busy),
      .lock_o   (chan_lock)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_chan
      assign wr_ptr_v[c]  = wr_chan && wr_ch == CW'(c) && wr_sel == SEL_PTR;
      assign wr_sema_v[c] = wr_chan && wr_ch == CW'(c) && wr_sel == SEL_SEMA;
      assign wr_stat_v[c] = wr_chan && wr_ch == CW'(c) && wr_sel == SEL_STAT;
      assign sema_nz[c]   = sema_v[c] != '0;

      cmdsem_chan #(.DW(DW), .SEMW(SEMW), .ERRW(ERRW), .LAT(LAT)) u_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .en_i      (chen_q[c]),
         .wr_ptr_i  (wr_ptr_v[c]),
         .wr_sema_i (wr_sema_v[c]),
         .wr_stat_i (wr_stat_v[c]),
         .wdata_i   (wr_data),
         .ptr_o     (ptr_v[c]),
         .sema_o    (sema_v[c]),
         .run_o     (chan_run[c]),
         .irqp_o    (irqp_v[c]),
         .err_o     (err_v[c]),
         .done_o    (chan_done[c])
      );
   end

   assign gclr_mask = (wr_glob && wr_addr[1:0] == GADDR_CLR) ? wr_data[NCH-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chen_q  <= '0;
         gstat_q <= '0;
      end else begin
         gstat_q <= (gstat_q & ~gclr_mask) | chan_done;
         if (wr_glob && wr_addr[1:0] == GADDR_EN) chen_q <= wr_data[NCH-1:0];
      end
   end

   logic [CW-1:0] rd_ch;
   assign rd_ch = rd_addr[2 +: CW];

   always_comb begin
      rd_data = '0;
      if (!rd_addr[AW-1]) begin
         case (rd_addr[1:0])
            GADDR_STAT: rd_data[NCH-1:0] = gstat_q;
            GADDR_EN:   rd_data[NCH-1:0] = chen_q;
            default:    rd_data = '0;
         endcase
      end else begin
         case (chan_sel_e'(rd_addr[1:0]))
            SEL_PTR:  rd_data = ptr_v[rd_ch];
            SEL_SEMA: rd_data[SEMW-1:0] = sema_v[rd_ch];
            SEL_STAT: begin
               rd_data[0] = chan_run[rd_ch];
               rd_data[1] = irqp_v[rd_ch];
               rd_data[STAT_ERR_LO +: ERRW] = err_v[rd_ch];
            end
            default:  rd_data = '0;
         endcase
      end
   end

   assign irq = |irqp_v;
endmodule

// File: rtl/cmdsem_checker.sv
module cmdsem_checker #(
   parameter int NCH = 4,
   localparam int CW = $clog2(NCH)
) (
   input logic           clk,
   input logic           rst_n,
   input logic           alloc_gnt,
   input logic           alloc_busy,
   input logic [CW-1:0]  alloc_id,
   input logic           rel_en,
   input logic [CW-1:0]  rel_id,
   input logic [NCH-1:0] chan_lock,
   input logic [NCH-1:0] chan_done,
   input logic [NCH-1:0] chan_run,
   input logic [NCH-1:0] sema_nz,
   input logic [NCH-1:0] chen_q,
   input logic [NCH-1:0] gstat_q,
   input logic           irq
);
   assert_busy_all_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_busy |-> (&chan_lock && !alloc_gnt));

   assert_grant_claims_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_gnt && !(rel_en && rel_id == alloc_id)) |=> chan_lock[$past(alloc_id)]);

   assert_done_sets_gstat_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (|chan_done) |=> ((gstat_q & $past(chan_done)) == $past(chan_done)));

   assert_start_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ((chan_run & ~$past(chan_run)) & ~$past(sema_nz & chen_q)) == '0);

   assert_irq_from_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(|chan_done));
endmodule

bind cmdsem_ctrl cmdsem_checker #(.NCH(NCH)) u_cmdsem_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .alloc_gnt  (alloc_gnt),
   .alloc_busy (alloc_busy),
   .alloc_id   (alloc_id),
   .rel_en     (rel_en),
   .rel_id     (rel_id),
   .chan_lock  (chan_lock),
   .chan_done  (chan_done),
   .chan_run   (chan_run),
   .sema_nz    (sema_nz),
   .chen_q     (chen_q),
   .gstat_q    (gstat_q),
   .irq        (irq)
);

// File: tb/cmdsem_ctrl_bench.sv
`timescale 1ns/1ps
module cmdsem_ctrl_bench;
   localparam int NCH = 4;
   localparam int LAT = 4;
   localparam int SMAX = 255;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [4:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [4:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        alloc_req = 1'b0;
   logic        alloc_gnt, alloc_busy, irq;
   logic [1:0]  alloc_id;
   logic        rel_en = 1'b0;
   logic [1:0]  rel_id = '0;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   cmdsem_ctrl u_cmdsem_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .alloc_req(alloc_req), .alloc_gnt(alloc_gnt),
      .alloc_id(alloc_id), .alloc_busy(alloc_busy), .rel_en(rel_en), .rel_id(rel_id), .irq(irq)
   );

   // behavioural reference model
   int  m_ptr [NCH];
   int  m_sema[NCH];
   int  m_cnt [NCH];
   int  m_ctl [NCH];
   int  m_err [NCH];
   bit  m_run [NCH];
   bit  m_irqp[NCH];
   bit  m_comp[NCH];
   int  m_gstat, m_chen, m_lock;

   function automatic int lowest_free(int lk);
      for (int i = 0; i < NCH; i++) if (!lk[i]) return i;
      return -1;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int c = 0; c < NCH; c++) begin
            m_ptr[c] = 0; m_sema[c] = 0; m_cnt[c] = 0; m_ctl[c] = 0;
            m_err[c] = 0; m_run[c] = 0; m_irqp[c] = 0;
         end
         m_gstat = 0; m_chen = 0; m_lock = 0;
      end else begin
         int lf;
         for (int c = 0; c < NCH; c++) m_comp[c] = m_run[c] && m_cnt[c] == 0;
         for (int c = 0; c < NCH; c++) begin
            bit st;
            int s;
            st = !m_run[c] && m_chen[c] && m_sema[c] != 0;
            s = m_sema[c];
            if (wr_en && wr_addr == {1'b1, 2'(c), 2'd1}) s = s + int'(wr_data[7:0]);
            if (s > SMAX) s = SMAX;
            if (m_comp[c] && m_ctl[c][0]) s = s - 1;
            m_sema[c] = s;
            if (wr_en && wr_addr == {1'b1, 2'(c), 2'd2}) begin
               m_err[c] = 0; m_irqp[c] = 0;
            end
            if (m_comp[c]) begin
               if (m_ctl[c][2]) m_err[c] = m_err[c] | 1;
               else if (m_ctl[c][1]) m_irqp[c] = 1;
            end
            if (st) begin
               m_run[c] = 1; m_cnt[c] = LAT - 1; m_ctl[c] = m_ptr[c] & 7;
            end else if (m_comp[c]) m_run[c] = 0;
            else if (m_run[c]) m_cnt[c] = m_cnt[c] - 1;
            if (wr_en && wr_addr == {1'b1, 2'(c), 2'd0}) m_ptr[c] = int'(wr_data);
         end
         if (wr_en && wr_addr == 5'd1) m_gstat = m_gstat & ~int'(wr_data[3:0]);
         for (int c = 0; c < NCH; c++) if (m_comp[c]) m_gstat = m_gstat | (1 << c);
         if (wr_en && wr_addr == 5'd2) m_chen = int'(wr_data[3:0]);
         lf = lowest_free(m_lock);
         if (rel_en) m_lock = m_lock & ~(1 << rel_id);
         if (alloc_req && lf >= 0) m_lock = m_lock | (1 << lf);
      end
   end

   function automatic logic [31:0] model_read(logic [4:0] a);
      int c;
      c = int'(a[3:2]);
      if (!a[4]) begin
         if (a[1:0] == 2'd0) return 32'(m_gstat);
         if (a[1:0] == 2'd2) return 32'(m_chen);
         return 32'h0;
      end
      case (a[1:0])
         2'd0: return 32'(m_ptr[c]);
         2'd1: return 32'(m_sema[c]);
         2'd2: return {16'h0, 8'(m_err[c]), 6'h0, m_irqp[c], m_run[c]};
         default: return 32'h0;
      endcase
   endfunction

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // compare everything every cycle, away from the edge
   always @(negedge clk) begin
      logic [31:0] e;
      string tag;
      int lf;
      #3;
      if (!finished) begin
         e = model_read(rd_addr);
         if (!rst_n)                      tag = "R1 reset read";
         else if (!rd_addr[4] && rd_addr[1:0] == 2'd0) tag = "R3 gstat";
         else if (!rd_addr[4])            tag = "R9 global";
         else if (rd_addr[1:0] == 2'd0)   tag = "R1 pointer";
         else if (rd_addr[1:0] == 2'd1)   tag = "R5 R10 semaphore";
         else if (rd_addr[1:0] == 2'd2)   tag = "R2 R4 R7 status";
         else                             tag = "R1 unused";
         check(rd_data === e, tag, rd_data, e);
         check(irq === (m_irqp[0] | m_irqp[1] | m_irqp[2] | m_irqp[3]), "R6 irq",
               32'(irq), 32'(m_irqp[0] | m_irqp[1] | m_irqp[2] | m_irqp[3]));
         lf = lowest_free(m_lock);
         check(alloc_gnt === (alloc_req && lf >= 0), "R8 grant", 32'(alloc_gnt), 32'(alloc_req && lf >= 0));
         check(alloc_busy === (alloc_req && lf < 0), "R8 busy", 32'(alloc_busy), 32'(alloc_req && lf < 0));
         if (alloc_req && lf >= 0)
            check(alloc_id === 2'(lf), "R8 lowest id", 32'(alloc_id), 32'(lf));
      end
   end

   always @(negedge clk) rd_addr <= rd_addr + 5'd1;

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic alloc_op(input bit req, input bit rel, input logic [1:0] rid);
      alloc_req = req; rel_en = rel; rel_id = rid;
      @(negedge clk);
      alloc_req = 1'b0; rel_en = 1'b0;
   endtask

   task automatic summary;
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not end, actual=hung expected=done");
      summary();
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(2);
      wr(5'd0, 32'hF);             // R9 write to address 0 ignored
      idle(2);
      wr(5'd2, 32'hF);             // R9 enable all
      wr(5'b10000, 32'h3);         // R5 R6 ch0 decrement + irq
      wr(5'b10001, 32'h1);         // R2 launch ch0
      idle(10);
      wr(5'd1, 32'h1);             // R9 clear gstat
      wr(5'b10010, 32'h0);         // R4 clear ch0 status
      wr(5'b10100, 32'h5);         // R7 ch1 error + decrement
      wr(5'b10101, 32'h1);
      idle(10);
      wr(5'b11000, 32'h0);         // R10 ch2 no decrement: repeats
      wr(5'b11001, 32'h1);
      idle(16);
      wr(5'd2, 32'hB);             // R9 disable ch2, running command completes
      idle(10);
      wr(5'd2, 32'h3);             // R2 ch3 disabled: stays idle
      wr(5'b11100, 32'h1);
      wr(5'b11101, 32'd200);       // R5 saturation
      wr(5'b11101, 32'h1C8);
      idle(36);
      wr(5'b10000, 32'h1);         // ch0 decrement only
      for (int i = 0; i < 14; i++) wr(5'b10001, 32'h1);   // R5 increment vs decrement collision
      for (int i = 0; i < 14; i++) wr(5'd1, 32'hF);       // R3 clear vs set collision
      wr(5'b10110, 32'h0);
      wr(5'b10101, 32'h3);
      for (int i = 0; i < 16; i++) wr(5'b10110, 32'h0);   // R4 status clear vs error collision
      idle(4);
      for (int i = 0; i < 4; i++) alloc_op(1'b1, 1'b0, 2'd0);  // R8 grants 0..3
      alloc_op(1'b1, 1'b0, 2'd0);                              // R8 busy
      alloc_op(1'b1, 1'b1, 2'd2);                              // R8 release not seen same cycle
      alloc_op(1'b1, 1'b0, 2'd0);                              // R8 gets 2
      alloc_op(1'b0, 1'b1, 2'd0);
      alloc_op(1'b0, 1'b1, 2'd3);
      alloc_op(1'b1, 1'b0, 2'd0);                              // R8 lowest of 0,3 is 0
      alloc_op(1'b1, 1'b0, 2'd0);
      idle(40);
      summary();
   end
endmodule